// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block keeps interrupt state for one processor across 256 vector numbers. It holds three bit vectors: a request vector that records vectors waiting for service, an in-service vector that records vectors the processor has taken and not yet retired, and a trigger vector that records which requests arrived as level-triggered. A larger vector number always has the higher priority. A software-written task priority and the highest in-service vector together give a processor priority. Requests whose priority class is not above that class are held back from the processor.

Interrupt sources, such as local timer and pin logic or an external bus, raise requests through a single set port. The processor side sees a registered pending line. It takes an interrupt with a one-cycle acknowledge strobe and retires it with a one-cycle end-of-interrupt strobe. The task priority and the spurious/enable register are loaded through a small write port. An acknowledge that the task priority blocks returns the spurious vector and changes nothing.

Top module: `vec_prio_ctrl`

## Requirements
- R1: After reset the pending line is 0, the processor priority is 0, the in-service vector is empty (eoi_valid 0), and acknowledge offers the spurious vector 0xFF (ack_spurious 1).
- R2: A set strobe sets the request bit of set_vector. With set_level=1 it also sets that vector's trigger bit, which ack_level reports when the vector is offered. A later edge request (set_level=0) does not clear the trigger bit.
- R3: When several requests are pending, acknowledge offers the highest-numbered one.
- R4: The pending line can be 1 only when bit 8 of the spurious/enable register is 1 and at least one request bit is set.
- R5: While the processor priority is nonzero, the pending line stays 0 if bits 7:4 of the top request are less than or equal to bits 7:4 of the processor priority.
- R6: Acknowledge offers the spurious vector (the low 8 bits of the spurious/enable register, ack_spurious=1) in three cases: the request vector is empty; the enable bit is 0; or the task priority is nonzero and the top request is less than or equal to it. In these cases an acknowledge strobe changes no state.
- R7: In all other cases, an acknowledge strobe clears the top request bit, sets the same in-service bit and offers that vector on ack_vector.
- R8: An end-of-interrupt strobe clears the highest set in-service bit. eoi_vector shows that vector while eoi_valid is 1.
- R9: A write with wr_sel=1 stores all 9 bits of wr_data in the spurious/enable register. A write with wr_sel=0 stores wr_data[7:0] as the task priority, and bit 8 is ignored.
- R10: The processor priority equals the task priority when the task priority's bits 7:4 are at least the class of the top in-service vector. Otherwise it is that class followed by a zero low nibble.
- R11: The pending line is registered. It reflects the state as it stood one clock before, so it changes one cycle after the state that drives it.
- R12: A set of the same vector in the cycle that acknowledge grants it leaves the request bit set, and the in-service bit also becomes set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_valid | input | 1 | Request strobe |
| set_vector | input | 8 | Vector number to request |
| set_level | input | 1 | 1 = level-triggered request, 0 = edge |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = task priority, 1 = spurious/enable register |
| wr_data | input | 9 | Write data |
| ack | input | 1 | Acknowledge strobe from the processor |
| ack_vector | output | 8 | Vector an acknowledge takes (or the spurious vector) |
| ack_spurious | output | 1 | 1 when an acknowledge would return the spurious vector |
| ack_level | output | 1 | Trigger bit of the offered vector |
| eoi | input | 1 | End-of-interrupt strobe |
| eoi_vector | output | 8 | Highest in-service vector |
| eoi_valid | output | 1 | In-service vector nonzero |
| ppr | output | 8 | Current processor priority |
| irq_pending | output | 1 | Registered interrupt-pending line |

## Verification
The bench builds the block with its defaults: 8-bit vector numbers and a 4-bit priority class. All 256 vectors, both end values 0x00 and 0xFF, and every one of the sixteen classes are therefore reachable. Random stimulus often lands in the same class as the task priority or the in-service vector. That exercises the equal-class cases of the gate and of acknowledge. The directed part covers a grant and a set of the same vector in one cycle, and multi-bit in-service retirement order.

// File: rtl/vpc_pkg.sv
package vpc_pkg;
  typedef enum logic {
    SEL_TASK = 1'b0,
    SEL_SPUR = 1'b1
  } vpc_wr_sel_e;

  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } vpc_trig_e;

  localparam int VPC_VEC_W_DEF = 8;
  localparam int VPC_CLS_W_DEF = 4;
endpackage

// File: rtl/vpc_prio_enc.sv
module vpc_prio_enc #(
  parameter int N  = 256,
  parameter int IW = 8
) (
  input  logic [N-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |vec;
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/vpc_ppr.sv
module vpc_ppr #(
  parameter int VEC_W = 8,
  parameter int CLS_W = 4
) (
  input  logic [VEC_W-1:0] tpr,
  input  logic             isr_any,
  input  logic [CLS_W-1:0] isr_cls,
  output logic [VEC_W-1:0] ppr
);
  localparam int SUB_W = VEC_W - CLS_W;

  function automatic logic [VEC_W-1:0] calc_ppr(
    input logic [VEC_W-1:0] t, input logic [CLS_W-1:0] c);
    if (t[VEC_W-1:SUB_W] >= c) return t;
    return {c, {SUB_W{1'b0}}};
  endfunction

  logic [CLS_W-1:0] cls_eff;
  assign cls_eff = isr_any ? isr_cls : '0;
  assign ppr     = calc_ppr(tpr, cls_eff);
endmodule

// File: rtl/vpc_gate.sv
module vpc_gate #(
  parameter int VEC_W = 8,
  parameter int CLS_W = 4
) (
  input  logic             sw_en,
  input  logic             irr_any,
  input  logic [CLS_W-1:0] irr_cls,
  input  logic [VEC_W-1:0] ppr,
  output logic             pend
);
  localparam int SUB_W = VEC_W - CLS_W;

  function automatic logic class_blocked(
    input logic [CLS_W-1:0] rc, input logic [VEC_W-1:0] p);
    return (p != '0) && (rc <= p[VEC_W-1:SUB_W]);
  endfunction

  assign pend = sw_en && irr_any && !class_blocked(irr_cls, ppr);
endmodule

// File: rtl/vec_prio_ctrl.sv
module vec_prio_ctrl #(
  parameter int VEC_W = vpc_pkg::VPC_VEC_W_DEF,
  parameter int CLS_W = vpc_pkg::VPC_CLS_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_valid,
  input  logic [VEC_W-1:0] set_vector,
  input  logic             set_level,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [VEC_W:0]   wr_data,
  input  logic             ack,
  output logic [VEC_W-1:0] ack_vector,
  output logic             ack_spurious,
  output logic             ack_level,
  input  logic             eoi,
  output logic [VEC_W-1:0] eoi_vector,
  output logic             eoi_valid,
  output logic [VEC_W-1:0] ppr,
  output logic             irq_pending
);
  import vpc_pkg::*;

  localparam int NUM_VEC = 1 << VEC_W;
  localparam int SUB_W   = VEC_W - CLS_W;
  localparam logic [VEC_W:0] SVR_RST = {1'b0, {VEC_W{1'b1}}};

  logic [NUM_VEC-1:0] irr_q, isr_q, tmr_q;
  logic [NUM_VEC-1:0] irr_d, isr_d, tmr_d;
  logic [VEC_W-1:0]   tpr_q, tpr_d;
  logic [VEC_W:0]     svr_q, svr_d;
  logic               irq_q;

  // named internal events for the checker
  logic               irr_any, isr_any;
  logic [VEC_W-1:0]   irr_top, isr_top;
  logic               sw_en;
  logic               tpr_block;
  logic               grant;
  logic               eoi_fire;
  logic               pend_now;
  logic [NUM_VEC-1:0] set_mask, grant_mask, eoi_mask;

  function automatic logic [NUM_VEC-1:0] onehot(input logic [VEC_W-1:0] v);
    return {{(NUM_VEC-1){1'b0}}, 1'b1} << v;
  endfunction

  function automatic logic tpr_blocks(
    input logic [VEC_W-1:0] t, input logic [VEC_W-1:0] top);
    return (t != '0) && (top <= t);
  endfunction

  vpc_prio_enc #(.N(NUM_VEC), .IW(VEC_W)) u_irr_enc (
    .vec(irr_q), .any(irr_any), .idx(irr_top)
  );

  vpc_prio_enc #(.N(NUM_VEC), .IW(VEC_W)) u_isr_enc (
    .vec(isr_q), .any(isr_any), .idx(isr_top)
  );

  vpc_ppr #(.VEC_W(VEC_W), .CLS_W(CLS_W)) u_ppr (
    .tpr(tpr_q), .isr_any(isr_any), .isr_cls(isr_top[VEC_W-1:SUB_W]), .ppr(ppr)
  );

  vpc_gate #(.VEC_W(VEC_W), .CLS_W(CLS_W)) u_gate (
    .sw_en(sw_en), .irr_any(irr_any), .irr_cls(irr_top[VEC_W-1:SUB_W]),
    .ppr(ppr), .pend(pend_now)
  );

  assign sw_en        = svr_q[VEC_W];
  assign tpr_block    = tpr_blocks(tpr_q, irr_top);
  assign ack_spurious = !irr_any || !sw_en || tpr_block;
  assign ack_vector   = ack_spurious ? svr_q[VEC_W-1:0] : irr_top;
  assign ack_level    = !ack_spurious && tmr_q[irr_top];
  assign eoi_vector   = isr_top;
  assign eoi_valid    = isr_any;
  assign irq_pending  = irq_q;

  assign grant    = ack && !ack_spurious;
  assign eoi_fire = eoi && isr_any;

  always_comb begin
    set_mask   = set_valid ? onehot(set_vector) : '0;
    grant_mask = grant     ? onehot(irr_top)    : '0;
    eoi_mask   = eoi_fire  ? onehot(isr_top)    : '0;
    irr_d = (irr_q & ~grant_mask) | set_mask;
    isr_d = (isr_q & ~eoi_mask) | grant_mask;
    tmr_d = tmr_q | ((set_level == TRIG_LEVEL) ? set_mask : '0);
    tpr_d = tpr_q;
    svr_d = svr_q;
    if (wr_en) begin
      if (wr_sel == SEL_SPUR) svr_d = wr_data;
      else                    tpr_d = wr_data[VEC_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr_q <= '0;
      isr_q <= '0;
      tmr_q <= '0;
      tpr_q <= '0;
      svr_q <= SVR_RST;
      irq_q <= 1'b0;
    end else begin
      irr_q <= irr_d;
      isr_q <= isr_d;
      tmr_q <= tmr_d;
      tpr_q <= tpr_d;
      svr_q <= svr_d;
      irq_q <= pend_now;
    end
  end
endmodule

// File: rtl/vpc_checker.sv
module vpc_checker #(
  parameter int VEC_W = 8,
  parameter int CLS_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ack,
  input logic             eoi,
  input logic             wr_en,
  input logic             irq_pending,
  input logic             ack_spurious,
  input logic             eoi_valid,
  input logic [VEC_W-1:0] ppr,
  input logic [VEC_W-1:0] tpr_q,
  input logic             sw_en,
  input logic             irr_any
);
  localparam int SUB_W = VEC_W - CLS_W;

  AST_PEND_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pending |-> $past(sw_en && irr_any)); // R4

  AST_GRANT_FILLS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !ack_spurious) |=> eoi_valid); // R7

  AST_SPURIOUS_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && ack_spurious && !eoi && !wr_en) |=> $stable(ppr)); // R6

  AST_PPR_LOW_FROM_TASK: assert property (@(posedge clk) disable iff (!rst_n)
    (ppr[SUB_W-1:0] != '0) |-> (ppr == tpr_q)); // R10

  AST_ISR_STAYS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (!eoi_valid && !ack) |=> !eoi_valid); // R8
endmodule

bind vec_prio_ctrl vpc_checker #(.VEC_W(VEC_W), .CLS_W(CLS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack(ack), .eoi(eoi), .wr_en(wr_en),
  .irq_pending(irq_pending), .ack_spurious(ack_spurious),
  .eoi_valid(eoi_valid), .ppr(ppr), .tpr_q(tpr_q), .sw_en(sw_en),
  .irr_any(irr_any)
);

// File: tb/vec_prio_ctrl_test.sv
module vec_prio_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       set_valid, set_level, wr_en, wr_sel, ack, eoi;
  logic [7:0] set_vector;
  logic [8:0] wr_data;
  logic [7:0] ack_vector, eoi_vector, ppr;
  logic       ack_spurious, ack_level, eoi_valid, irq_pending;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [255:0] m_irr, m_isr, m_tmr;
  logic [7:0]   m_tpr;
  logic [8:0]   m_svr;
  bit           m_pend_prev;

  always #2 clk = ~clk;

  vec_prio_ctrl uut (
    .clk(clk), .rst_n(rst_n), .set_valid(set_valid), .set_vector(set_vector),
    .set_level(set_level), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ack(ack), .ack_vector(ack_vector), .ack_spurious(ack_spurious),
    .ack_level(ack_level), .eoi(eoi), .eoi_vector(eoi_vector),
    .eoi_valid(eoi_valid), .ppr(ppr), .irq_pending(irq_pending)
  );

  function automatic int top_of(input logic [255:0] v);
    for (int i = 255; i >= 0; i--) if (v[i]) return i;
    return -1;
  endfunction

  function automatic int exp_ppr();
    int it = top_of(m_isr);
    int ic = (it < 0) ? 0 : (it >> 4);
    int tc = m_tpr >> 4;
    return (tc >= ic) ? int'(m_tpr) : (ic << 4);
  endfunction

  function automatic bit exp_spur();
    int rt = top_of(m_irr);
    return (rt < 0) || !m_svr[8] || (m_tpr != 0 && rt <= int'(m_tpr));
  endfunction

  function automatic bit exp_pend();
    int rt = top_of(m_irr);
    int p  = exp_ppr();
    if (!m_svr[8] || rt < 0) return 0;
    if (p != 0 && (rt >> 4) <= (p >> 4)) return 0;
    return 1;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_outputs();
    int rt = top_of(m_irr);
    int it = top_of(m_isr);
    bit sp = exp_spur();
    int av = sp ? int'(m_svr[7:0]) : rt;
    chk(irq_pending == m_pend_prev, "R5/R11 pending", irq_pending, m_pend_prev);
    chk(ppr == exp_ppr(), "R10 ppr", ppr, exp_ppr());
    chk(ack_spurious == sp, "R6 spurious flag", ack_spurious, sp);
    chk(ack_vector == av, sp ? "R6 spurious vector" : "R7 offered vector", ack_vector, av);
    chk(ack_level == (!sp && m_tmr[rt[7:0]]), "R2 trigger", ack_level, !sp && m_tmr[rt[7:0]]);
    chk(eoi_valid == (it >= 0), "R8 isr valid", eoi_valid, it >= 0);
    if (it >= 0) chk(eoi_vector == it, "R8 isr top", eoi_vector, it);
  endtask

  task automatic step(input bit sv, input int vec, input bit lvl, input bit a,
                      input bit e, input bit we, input bit sel, input int wd);
    int rt, it;
    bit sp;
    set_valid = sv; set_vector = vec[7:0]; set_level = lvl;
    ack = a; eoi = e; wr_en = we; wr_sel = sel; wr_data = wd[8:0];
    check_outputs();
    rt = top_of(m_irr);
    it = top_of(m_isr);
    sp = exp_spur();
    m_pend_prev = exp_pend();
    @(posedge clk);
    if (e && it >= 0) m_isr[it] = 1'b0;
    if (a && !sp) begin
      m_irr[rt] = 1'b0;
      m_isr[rt] = 1'b1;
    end
    if (sv) begin
      m_irr[vec[7:0]] = 1'b1;
      if (lvl) m_tmr[vec[7:0]] = 1'b1;
    end
    if (we) begin
      if (sel) m_svr = wd[8:0];
      else     m_tpr = wd[7:0];
    end
    @(negedge clk);
  endtask

  task automatic idle();           step(0, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic setv(input int v, input bit l); step(1, v, l, 0, 0, 0, 0, 0); endtask
  task automatic do_ack();         step(0, 0, 0, 1, 0, 0, 0, 0); endtask
  task automatic do_eoi();         step(0, 0, 0, 0, 1, 0, 0, 0); endtask
  task automatic wr(input bit s, input int d); step(0, 0, 0, 0, 0, 1, s, d); endtask

  task automatic do_reset();
    rst_n = 1'b0;
    set_valid = 0; set_vector = 0; set_level = 0; ack = 0; eoi = 0;
    wr_en = 0; wr_sel = 0; wr_data = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_irr = '0; m_isr = '0; m_tmr = '0; m_tpr = 8'h00; m_svr = 9'h0FF;
    m_pend_prev = 0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0017));
    do_reset();
    // R1: reset state
    chk(irq_pending == 0, "R1 pending", irq_pending, 0);
    chk(ppr == 0, "R1 ppr", ppr, 0);
    chk(ack_spurious && ack_vector == 8'hFF, "R1 ack", ack_vector, 8'hFF);
    chk(eoi_valid == 0, "R1 isr", eoi_valid, 0);

    // R9: 9-bit spurious register, task priority drops bit 8
    wr(1, 9'h1A5);
    chk(ack_vector == 8'hA5, "R9 spurious low byte", ack_vector, 8'hA5);
    wr(0, 9'h130);
    chk(ppr == 8'h30, "R9 task byte", ppr, 8'h30);
    wr(0, 0);

    // R4 / R11: enable gating and registered timing
    wr(1, 9'h0FF);
    setv(8'h40, 0);
    idle();
    chk(irq_pending == 0, "R4 disabled", irq_pending, 0);
    wr(1, 9'h1FF);
    chk(irq_pending == 0, "R11 before", irq_pending, 0);
    idle();
    chk(irq_pending == 1, "R11 after", irq_pending, 1);
    do_ack();

    // R3 / R2: highest first, level trigger reported
    setv(8'h10, 0); setv(8'hFF, 1); setv(8'h80, 0);
    idle();
    chk(ack_vector == 8'hFF, "R3 highest", ack_vector, 8'hFF);
    chk(ack_level == 1, "R2 level", ack_level, 1);
    do_ack();
    chk(eoi_vector == 8'hFF, "R7 isr set", eoi_vector, 8'hFF);
    chk(ack_vector == 8'h80, "R7 next", ack_vector, 8'h80);
    idle(); idle();
    // R5: class gate against ppr 0xF0
    chk(irq_pending == 0, "R5 blocked", irq_pending, 0);
    repeat (2) do_eoi();
    chk(eoi_valid == 0, "R8 cleared", eoi_valid, 0);
    idle();
    chk(irq_pending == 1, "R5 released", irq_pending, 1);

    // R6: task priority blocks acknowledge
    wr(0, 8'h90);
    chk(ack_spurious == 1, "R6 blocked", ack_spurious, 1);
    do_ack();
    wr(0, 0);
    chk(ack_vector == 8'h80, "R6 unchanged", ack_vector, 8'h80);

    // R12 / R2 / R8
    do_reset();
    wr(1, 9'h1FF);
    setv(8'h22, 1);
    setv(8'h22, 0);
    chk(ack_level == 1, "R2 sticky", ack_level, 1);
    step(1, 8'h22, 0, 1, 0, 0, 0, 0);
    chk(ack_vector == 8'h22, "R12 request kept", ack_vector, 8'h22);
    chk(eoi_vector == 8'h22, "R12 isr set", eoi_vector, 8'h22);
    setv(8'h50, 0);
    do_ack();
    chk(eoi_vector == 8'h50, "R8 top isr", eoi_vector, 8'h50);
    do_eoi();
    chk(eoi_vector == 8'h22, "R8 order", eoi_vector, 8'h22);

    // constrained random
    for (int n = 0; n < 6000; n++) begin
      int r = $urandom_range(0, 99);
      if (n % 1500 == 0) begin do_reset(); wr(1, 9'h100 | $urandom_range(0, 255)); end
      if (r < 40)
        step(1, $urandom_range(0, 255), $urandom_range(0, 1), $urandom_range(0, 3) == 0, 0, 0, 0, 0);
      else if (r < 65) step(0, 0, 0, 1, $urandom_range(0, 7) == 0, 0, 0, 0);
      else if (r < 85) step($urandom_range(0, 1), $urandom_range(0, 255), 0, 0, 1, 0, 0, 0);
      else if (r < 95) wr(0, ($urandom_range(0, 1) == 0) ? 0 : $urandom_range(0, 511));
      else wr(1, (($urandom_range(0, 9) == 0) ? 0 : 9'h100) | $urandom_range(0, 255));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule